// File: doc/BRIEF.md
# Tone Pair Steering and Key Code Latch

This block sits behind a dual-tone detector. Each clock cycle it sees an early-presence flag, which is high while the detector recognises a valid tone pair, and the row and column indices of that pair. Digital counters take the place of a resistor-capacitor timing network. A tone pair is accepted only after presence has persisted for a programmable tone-present guard time. It is then released only after absence has persisted for a programmable tone-absent guard time. Both timers share one up/down steering counter, which gives hysteresis: short dropouts are absorbed, and so are short bursts.

On acceptance the block stores the 4-bit key code in a latch. After a short settle delay it raises a delayed-steering flag. The latch drives a tri-state bus while output-enable is high. An inhibit input stops the four column-3 (extended) keys from being accepted, so the latch keeps its previous code. A power-down input forces the steering logic back to idle.

The steering controller has three states, with these transitions:
- IDLE to SETTLE when the qualified presence has filled the counter. The latch loads in this transition.
- SETTLE to HELD after the settle delay.
- SETTLE or HELD to IDLE when absence has drained the counter.
- Any state to IDLE while power-down is high.

Top module: `tone_steer_latch`

## Requirements
- R1: After reset the latch holds 0000, the delayed-steering flag, the guard output and data-valid are low, and the steering counter is empty.
- R2: A pair is accepted (latch loads) at the clock edge on which presence has been sampled high for GUARD_ON consecutive cycles from an empty counter; one cycle fewer does not load.
- R3: Codes with row index r (0..3, low to high frequency) and column index c (0..3): for c<3 and r<3 the code is 3r+c+1; row 3 gives 1011, 1010, 1100 for columns 0, 1, 2; column 3 gives 1101, 1110, 1111, 0000 for rows 0..3.
- R4: The guard output is high while the controller is in SETTLE or HELD and presence is high, and is low in IDLE.
- R5: The delayed-steering flag rises SETTLE_CYC clock edges after the edge that loads the latch, and the latch does not change while the flag is high.
- R6: From HELD, the flag falls at the edge on which presence has been sampled low for GUARD_OFF consecutive cycles.
- R7: A dropout shorter than GUARD_OFF cycles keeps the flag high and does not reload the latch.
- R8: A different pair that follows without a valid pause is not accepted; the latch keeps the earlier code.
- R9: While inhibit is high, column-3 pairs are never accepted (flag and guard stay low, latch unchanged), while other pairs are accepted normally.
- R10: With output-enable high the bus shows the latch; with it low the bus is released (high impedance).
- R11: Power-down high returns the controller to IDLE on the next edge and empties the counter: flag and guard go low, and the latch keeps its code.
- R12: Data-valid is high when output-enable is high and at least one pair has been accepted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Forces steering to idle |
| early_pres | input | 1 | Tone-pair presence from the detector |
| row_idx | input | 2 | Low-group tone index |
| col_idx | input | 2 | High-group tone index |
| inhibit_ext | input | 1 | Blocks column-3 pairs |
| out_en | input | 1 | Bus drive enable |
| key_bus | output | 4 | Tri-state key code bus |
| dly_steer | output | 1 | Delayed-steering flag |
| guard_out | output | 1 | Guard-time status |
| data_valid | output | 1 | Bus carries an accepted code |

## Verification
Presence is driven as bursts one cycle short of and exactly equal to the tone-present guard time, which shows where the acceptance edge falls. All sixteen row and column pairs are accepted in turn, which separates the code mapping. A dropout one cycle short of the pause time is followed by a directly substituted pair, which shows that the hysteresis absorbs dropouts and that a pause is needed before a new key. Runs with inhibit set, with power-down asserted mid-hold, and with output-enable toggled show what each of those inputs blocks, clears or keeps.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_HELD   = 2'd2
    } steer_state_t;
endpackage

// File: rtl/keycode_enc.sv
module keycode_enc (
    input  logic [1:0] row_idx,
    input  logic [1:0] col_idx,
    output logic [3:0] key_code
);
    always_comb begin
        if (col_idx == 2'd3) begin
            key_code = 4'd13 + {2'b00, row_idx};
        end else if (row_idx != 2'd3) begin
            key_code = 4'(3 * row_idx) + {2'b00, col_idx} + 4'd1;
        end else begin
            unique case (col_idx)
                2'd0:    key_code = 4'b1011;
                2'd1:    key_code = 4'b1010;
                default: key_code = 4'b1100;
            endcase
        end
    end
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
    import tsl_pkg::*;
#(
    parameter int GUARD_ON   = 16,
    parameter int GUARD_OFF  = 12,
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic early_pres,
    input  logic blocked,
    output logic load,
    output logic guard_out,
    output logic dly_steer
);
    localparam int MAXG = (GUARD_ON > GUARD_OFF) ? GUARD_ON : GUARD_OFF;
    localparam int CW   = $clog2(MAXG + 1);
    localparam int SW   = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] ON_TOP  = CW'(GUARD_ON - 1);
    localparam logic [CW-1:0] OFF_TOP = CW'(GUARD_OFF);
    localparam logic [SW-1:0] SET_TOP = SW'(SETTLE_CYC - 1);

    steer_state_t state, state_nx;
    logic [CW-1:0] cnt;
    logic [SW-1:0] scnt;
    logic qual;
    logic full_hit;
    logic drain_hit;

    assign qual      = early_pres && !blocked;
    assign full_hit  = (state == ST_IDLE) && qual && (cnt == ON_TOP);
    assign drain_hit = (state != ST_IDLE) && !early_pres && (cnt == CW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (full_hit) state_nx = ST_SETTLE;
            ST_SETTLE: if (drain_hit) state_nx = ST_IDLE;
                       else if (scnt == SET_TOP) state_nx = ST_HELD;
            ST_HELD:   if (drain_hit) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (pwr_down) state_nx = ST_IDLE;
    end

    // outputs
    always_comb begin
        load      = full_hit && !pwr_down;
        guard_out = (state != ST_IDLE) && early_pres;
        dly_steer = (state == ST_HELD);
    end

    // steering up/down counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pwr_down) begin
            cnt <= '0;
        end else if (state == ST_IDLE) begin
            if (qual)            cnt <= (cnt == ON_TOP) ? OFF_TOP : cnt + 1'b1;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
        end else begin
            if (early_pres) begin
                if (cnt < OFF_TOP) cnt <= cnt + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // settle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   scnt <= '0;
        else if (state != ST_SETTLE)  scnt <= '0;
        else if (scnt != SET_TOP)     scnt <= scnt + 1'b1;
    end
endmodule

// File: rtl/code_reg.sv
module code_reg #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_lat,
    output logic              seen
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_lat <= '0;
            seen     <= 1'b0;
        end else if (load) begin
            code_lat <= code_in;
            seen     <= 1'b1;
        end
    end
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch #(
    parameter int GUARD_ON   = 16,
    parameter int GUARD_OFF  = 12,
    parameter int SETTLE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    input  logic       early_pres,
    input  logic [1:0] row_idx,
    input  logic [1:0] col_idx,
    input  logic       inhibit_ext,
    input  logic       out_en,
    output wire  [3:0] key_bus,
    output logic       dly_steer,
    output logic       guard_out,
    output logic       data_valid
);
    logic [3:0] key_code;
    logic [3:0] code_lat;
    logic       load;
    logic       seen;
    logic       blocked;

    assign blocked = inhibit_ext && (col_idx == 2'd3);

    keycode_enc enc_i (
        .row_idx (row_idx),
        .col_idx (col_idx),
        .key_code(key_code)
    );

    steer_ctrl #(
        .GUARD_ON  (GUARD_ON),
        .GUARD_OFF (GUARD_OFF),
        .SETTLE_CYC(SETTLE_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .early_pres(early_pres),
        .blocked   (blocked),
        .load      (load),
        .guard_out (guard_out),
        .dly_steer (dly_steer)
    );

    code_reg #(.CODE_W(4)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .code_in (key_code),
        .code_lat(code_lat),
        .seen    (seen)
    );

    assign key_bus    = out_en ? code_lat : 4'bzzzz;
    assign data_valid = out_en && seen;
endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down,
    input logic       early_pres,
    input logic       inhibit_ext,
    input logic       out_en,
    input logic [3:0] key_bus,
    input logic [3:0] code_lat,
    input logic       dly_steer,
    input logic       guard_out
);
    a_r4_guard_needs_pres: assert property (@(posedge clk) disable iff (!rst_n)
        guard_out |-> early_pres);

    a_r5_code_stable_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_steer && $past(dly_steer)) |-> $stable(code_lat));

    a_r6_fall_needs_absence: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dly_steer) && !$past(pwr_down)) |-> !$past(early_pres));

    a_r9_inhibit_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(code_lat) && $past(inhibit_ext)) |-> (code_lat >= 4'd1 && code_lat <= 4'd12));

    a_r10_bus_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (key_bus == code_lat));

    a_r11_powerdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!dly_steer && !guard_out));
endmodule

bind tone_steer_latch tone_steer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .early_pres (early_pres),
    .inhibit_ext(inhibit_ext),
    .out_en     (out_en),
    .key_bus    (key_bus),
    .code_lat   (code_lat),
    .dly_steer  (dly_steer),
    .guard_out  (guard_out)
);

// File: tb/tone_steer_latch_tb.sv
module tone_steer_latch_tb_top;
    localparam int GON  = 16;
    localparam int GOFF = 12;
    localparam int SET  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down = 1'b0;
    logic early_pres = 1'b0;
    logic [1:0] row_idx = '0;
    logic [1:0] col_idx = '0;
    logic inhibit_ext = 1'b0;
    logic out_en = 1'b1;
    wire  [3:0] key_bus;
    logic dly_steer, guard_out, data_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tone_steer_latch #(.GUARD_ON(GON), .GUARD_OFF(GOFF), .SETTLE_CYC(SET)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .early_pres(early_pres),
        .row_idx(row_idx), .col_idx(col_idx), .inhibit_ext(inhibit_ext),
        .out_en(out_en), .key_bus(key_bus), .dly_steer(dly_steer),
        .guard_out(guard_out), .data_valid(data_valid)
    );

    function automatic logic [3:0] exp_code(input int r, input int c);
        if (c == 3) return (r == 3) ? 4'b0000 : 4'(13 + r);
        if (r < 3)  return 4'(r * 3 + c + 1);
        case (c)
            0: return 4'b1011;
            1: return 4'b1010;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // press a key, checking acceptance and settle timing, then hold
    task automatic accept(input int r, input int c, input string req);
        row_idx = 2'(r); col_idx = 2'(c); early_pres = 1'b1;
        cyc(GON - 1);
        chk({req, " pre-accept guard"}, {3'b0, guard_out}, 4'd0);
        cyc(1);
        chk({req, " code"}, key_bus, exp_code(r, c));
        chk("R4 guard after accept", {3'b0, guard_out}, 4'd1);
        cyc(SET - 1);
        chk("R5 flag still low", {3'b0, dly_steer}, 4'd0);
        cyc(1);
        chk("R5 flag high", {3'b0, dly_steer}, 4'd1);
    endtask

    task automatic release_full();
        early_pres = 1'b0;
        cyc(GOFF - 1);
        chk("R6 flag held before pause", {3'b0, dly_steer}, 4'd1);
        cyc(1);
        chk("R6 flag low after pause", {3'b0, dly_steer}, 4'd0);
        chk("R4 guard low in idle", {3'b0, guard_out}, 4'd0);
        cyc(GON + 2);
    endtask

    task automatic t_reset();
        chk("R1 code", key_bus, 4'd0);
        chk("R1 flag", {3'b0, dly_steer}, 4'd0);
        chk("R1 guard", {3'b0, guard_out}, 4'd0);
        chk("R12 valid before accept", {3'b0, data_valid}, 4'd0);
    endtask

    task automatic t_short_burst();
        row_idx = 2'd1; col_idx = 2'd1; early_pres = 1'b1;
        cyc(GON - 1);
        early_pres = 1'b0;
        cyc(1);
        chk("R2 short burst no load", key_bus, 4'd0);
        chk("R2 short burst no valid", {3'b0, data_valid}, 4'd0);
        cyc(GON + 2);
    endtask

    task automatic t_all_keys();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                accept(r, c, "R3");
                release_full();
            end
        chk("R12 valid after accept", {3'b0, data_valid}, 4'd1);
    endtask

    task automatic t_dropout_and_swap();
        accept(2, 1, "R2");
        early_pres = 1'b0;
        cyc(GOFF - 1);
        early_pres = 1'b1;
        cyc(GOFF);
        chk("R7 flag kept over dropout", {3'b0, dly_steer}, 4'd1);
        row_idx = 2'd0; col_idx = 2'd2;
        cyc(GON + GOFF);
        chk("R8 no swap without pause", key_bus, exp_code(2, 1));
        chk("R8 flag still held", {3'b0, dly_steer}, 4'd1);
        release_full();
        accept(0, 2, "R8 after pause");
        release_full();
    endtask

    task automatic t_inhibit();
        accept(1, 1, "R9 base");
        release_full();
        inhibit_ext = 1'b1;
        row_idx = 2'd0; col_idx = 2'd3; early_pres = 1'b1;
        cyc(GON + SET + 6);
        chk("R9 ext blocked code", key_bus, exp_code(1, 1));
        chk("R9 ext blocked flag", {3'b0, dly_steer}, 4'd0);
        chk("R9 ext blocked guard", {3'b0, guard_out}, 4'd0);
        early_pres = 1'b0;
        cyc(GON + 2);
        accept(2, 2, "R9 normal key under inhibit");
        release_full();
        inhibit_ext = 1'b0;
    endtask

    task automatic t_power_down();
        accept(0, 0, "R11 base");
        pwr_down = 1'b1;
        cyc(1);
        chk("R11 flag cleared", {3'b0, dly_steer}, 4'd0);
        chk("R11 guard cleared", {3'b0, guard_out}, 4'd0);
        chk("R11 latch kept", key_bus, exp_code(0, 0));
        pwr_down = 1'b0;
        early_pres = 1'b0;
        cyc(GON + 2);
    endtask

    task automatic t_bus();
        out_en = 1'b0;
        cyc(1);
        n_tests++;
        if (key_bus === exp_code(0, 0)) begin
            n_fail++;
            $display("FAIL R10 bus released: actual %b expected z", key_bus);
        end
        chk("R12 valid low without enable", {3'b0, data_valid}, 4'd0);
        out_en = 1'b1;
        cyc(1);
        chk("R10 bus driven", key_bus, exp_code(0, 0));
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_short_burst();
        t_all_keys();
        t_dropout_and_swap();
        t_inhibit();
        t_power_down();
        t_bus();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule